// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits in front of the line controller of a mid-level cache that keeps coherence with an outer shared level and an inner private cache. Three message queues compete for it: responses from the outer level, requests forwarded by the outer level, and requests or replies coming up from the inner cache. Each cycle the block picks the head of one queue by fixed priority and presents that head's address on a lookup port. The controller answers in the same cycle with the line's state, hit flag, free-way flag, victim line information and the transaction tracker's pending-ack count.

The block turns the chosen message into one coherence event code and a target address. The target is the victim's address when an inner request misses and no way is free. It also produces the dequeue strobe for the chosen queue. Events are registered, so they appear one cycle after the head is accepted. Dequeue strobes are combinational, so a queue pops in the same cycle its head is accepted. A message whose type code has no meaning is popped without an event, and a sticky error flag is raised.

Top module: `coh_event_classifier`

## Requirements
- R1: Queue priority is fixed: outer responses first, forwarded requests second, inner messages last. `lookup_addr` shows the head address of the highest-priority valid queue, and only that queue's dequeue strobe may rise.
- R2: At most one event is issued per cycle. A head accepted in cycle N (valid, not stalled) pops in cycle N through its combinational dequeue strobe, and its event is on `ev_valid`/`ev_code`/`ev_addr` in cycle N+1. With no queue valid, `ev_valid` is low in the next cycle.
- R3: Response types are encoded 0 data, 1 exclusive data, 2 ack, 3 writeback ack. Exclusive data gives event 12 and writeback ack gives event 17.
- R4: A data response (type 0) gives event 13 when `line_state` is 7 (waiting for shared data) and `rsp_from_peer` is high. Otherwise it gives event 14 when `pend_acks` equals `rsp_acks`, and event 11 when they differ.
- R5: An ack response (type 2) gives event 16 when `pend_acks` equals `rsp_acks`, and event 15 otherwise.
- R6: Forwarded types are encoded 0 invalidate, 1 read, 2 write, 3 upgrade. When `line_hit` is high and `line_state` is one of 1, 3, 5, 12, 13, 14 or 16 (copy held by the inner cache), every forwarded type gives event 8. Otherwise invalidate gives 5, read gives 6, and write and upgrade give 7.
- R7: Inner types are encoded 0 read, 1 write, 2 upgrade, 3 writeback, 4 invalidate-reply with data, 5 invalidate-reply without data. Type 4 gives event 3 and type 5 gives event 4, regardless of hit or free-way status.
- R8: An inner type 0 to 3 that hits, or that misses with `way_free` high, gives event 0 (read), 1 (write or upgrade) or 2 (writeback). The event carries the head address.
- R9: An inner type 0 to 3 that misses with `way_free` low carries `victim_addr`. It gives event 9 when `victim_valid` is high and `victim_state` is in the inner-held set of R6, and event 10 otherwise. The inner queue is not dequeued.
- R10: While `ctl_stall` is high, no queue is dequeued and no event is issued in the next cycle.
- R11: An undefined type (response type 4 to 7, inner type 6 or 7) is dequeued and produces no event. It sets `err_sticky`, which stays high until reset.
- R12: Synchronous active-high reset clears `ev_valid` and `err_sticky`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rsp_valid | input | 1 | Outer response queue has a head |
| rsp_type | input | 3 | Response type code |
| rsp_from_peer | input | 1 | Response sent by a same-level cache |
| rsp_acks | input | ACK_W | Ack count carried by the response |
| rsp_addr | input | ADDR_W | Response line address |
| fwd_valid | input | 1 | Forwarded request queue has a head |
| fwd_type | input | 2 | Forwarded request type code |
| fwd_addr | input | ADDR_W | Forwarded request line address |
| inr_valid | input | 1 | Inner queue has a head |
| inr_type | input | 3 | Inner message type code |
| inr_addr | input | ADDR_W | Inner message line address |
| line_state | input | 5 | State of the line at lookup_addr |
| line_hit | input | 1 | Line at lookup_addr is present |
| way_free | input | 1 | The set of lookup_addr has a free way |
| victim_addr | input | ADDR_W | Replacement candidate address |
| victim_valid | input | 1 | Replacement candidate is present |
| victim_state | input | 5 | Replacement candidate state |
| pend_acks | input | ACK_W | Tracker's outstanding ack count |
| ctl_stall | input | 1 | Controller cannot accept an event |
| lookup_addr | output | ADDR_W | Head address of the selected queue |
| deq_rsp | output | 1 | Pop response queue |
| deq_fwd | output | 1 | Pop forwarded queue |
| deq_inr | output | 1 | Pop inner queue |
| ev_valid | output | 1 | Registered event valid |
| ev_code | output | 5 | Registered event code |
| ev_addr | output | ADDR_W | Registered event target address |
| err_sticky | output | 1 | Undefined type seen since reset |

## Verification
The hardest case to reach is the no-free-way miss. Here the event must name the victim rather than the head, and the inner queue must stay put so the same request can retry. Reaching it needs the higher-priority queues idle, a miss, a full set and a chosen victim state, all in one cycle. Each stimulus vector drives the whole lookup answer directly, which sets up this case exactly. The vectors cover both victim outcomes and also check that no pop occurs. A second hard case is telling the three data-response events apart. That needs the waiting-shared state together with the peer flag, and equal and unequal ack counts. Dedicated vectors cover each combination.

// File: rtl/cec_pkg.sv
package cec_pkg;

  typedef enum logic [4:0] {
    EV_LOAD          = 5'd0,
    EV_STORE         = 5'd1,
    EV_WRITEBACK     = 5'd2,
    EV_IN_DATA_ACK   = 5'd3,
    EV_IN_ACK        = 5'd4,
    EV_INV           = 5'd5,
    EV_PEER_RD       = 5'd6,
    EV_PEER_WR       = 5'd7,
    EV_RECALL_OTHER  = 5'd8,
    EV_RECALL_OWN    = 5'd9,
    EV_EVICT         = 5'd10,
    EV_FILL          = 5'd11,
    EV_FILL_EXCL     = 5'd12,
    EV_FILL_PEER     = 5'd13,
    EV_FILL_LAST     = 5'd14,
    EV_ACK           = 5'd15,
    EV_ACK_LAST      = 5'd16,
    EV_WB_DONE       = 5'd17
  } ev_e;

  localparam logic [4:0] LS_INVALID    = 5'd0;
  localparam logic [4:0] LS_SH_INNER   = 5'd1;
  localparam logic [4:0] LS_EX_INNER   = 5'd3;
  localparam logic [4:0] LS_MOD_INNER  = 5'd5;
  localparam logic [4:0] LS_WAIT_SH    = 5'd7;
  localparam logic [4:0] LS_SH_RCL     = 5'd12;
  localparam logic [4:0] LS_EX_RCL     = 5'd13;
  localparam logic [4:0] LS_MOD_RCL    = 5'd14;
  localparam logic [4:0] LS_UPG_RCL    = 5'd16;

  localparam logic [2:0] RT_DATA      = 3'd0;
  localparam logic [2:0] RT_DATA_EXCL = 3'd1;
  localparam logic [2:0] RT_ACK       = 3'd2;
  localparam logic [2:0] RT_WB_ACK    = 3'd3;

  localparam logic [1:0] FT_INV  = 2'd0;
  localparam logic [1:0] FT_READ = 2'd1;
  localparam logic [1:0] FT_WRITE = 2'd2;
  localparam logic [1:0] FT_UPG  = 2'd3;

  localparam logic [2:0] IT_READ     = 3'd0;
  localparam logic [2:0] IT_WRITE    = 3'd1;
  localparam logic [2:0] IT_UPG      = 3'd2;
  localparam logic [2:0] IT_WB       = 3'd3;
  localparam logic [2:0] IT_INV_DATA = 3'd4;
  localparam logic [2:0] IT_INV_ACK  = 3'd5;

  localparam int NUM_Q = 3;
  localparam int Q_RSP = 0;
  localparam int Q_FWD = 1;
  localparam int Q_INR = 2;

  function automatic logic inner_holds(input logic [4:0] st);
    case (st)
      LS_SH_INNER, LS_EX_INNER, LS_MOD_INNER,
      LS_SH_RCL, LS_EX_RCL, LS_MOD_RCL, LS_UPG_RCL: inner_holds = 1'b1;
      default: inner_holds = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/cec_prio_arb.sv
module cec_prio_arb #(
  parameter int NQ = 3
) (
  input  logic [NQ-1:0] req,
  output logic [NQ-1:0] pick
);
  logic [NQ-1:0] above;

  assign above[0] = 1'b0;

  for (genvar i = 0; i < NQ; i++) begin : g_slot
    assign pick[i] = req[i] & ~above[i];
    if (i + 1 < NQ) begin : g_chain
      assign above[i+1] = above[i] | req[i];
    end
  end
endmodule

// File: rtl/cec_onehot_mux.sv
module cec_onehot_mux #(
  parameter int NQ = 3,
  parameter int W  = 32
) (
  input  logic [NQ*W-1:0] din,
  input  logic [NQ-1:0]   sel,
  output logic [W-1:0]    dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NQ; i++) begin
      if (sel[i]) dout = dout | din[i*W +: W];
    end
  end
endmodule

// File: rtl/cec_classify.sv
module cec_classify
  import cec_pkg::*;
#(
  parameter int ACK_W = 4
) (
  input  logic [NUM_Q-1:0] pick,
  input  logic [2:0]       rsp_type,
  input  logic             rsp_from_peer,
  input  logic [ACK_W-1:0] rsp_acks,
  input  logic [1:0]       fwd_type,
  input  logic [2:0]       inr_type,
  input  logic [4:0]       line_state,
  input  logic             line_hit,
  input  logic             way_free,
  input  logic             victim_valid,
  input  logic [4:0]       victim_state,
  input  logic [ACK_W-1:0] pend_acks,
  output ev_e              code,
  output logic             use_victim,
  output logic             bad_type
);
  logic acks_done;
  logic held_fwd;
  logic held_vic;

  assign acks_done = (pend_acks == rsp_acks);
  assign held_fwd  = line_hit & inner_holds(line_state);
  assign held_vic  = victim_valid & inner_holds(victim_state);

  always_comb begin
    code       = EV_LOAD;
    use_victim = 1'b0;
    bad_type   = 1'b0;
    if (pick[Q_RSP]) begin
      case (rsp_type)
        RT_DATA: begin
          if (line_state == LS_WAIT_SH && rsp_from_peer) code = EV_FILL_PEER;
          else if (acks_done)                             code = EV_FILL_LAST;
          else                                            code = EV_FILL;
        end
        RT_DATA_EXCL: code = EV_FILL_EXCL;
        RT_ACK:       code = acks_done ? EV_ACK_LAST : EV_ACK;
        RT_WB_ACK:    code = EV_WB_DONE;
        default:      bad_type = 1'b1;
      endcase
    end else if (pick[Q_FWD]) begin
      if (held_fwd) begin
        code = EV_RECALL_OTHER;
      end else begin
        case (fwd_type)
          FT_INV:  code = EV_INV;
          FT_READ: code = EV_PEER_RD;
          default: code = EV_PEER_WR;
        endcase
      end
    end else if (pick[Q_INR]) begin
      case (inr_type)
        IT_INV_DATA: code = EV_IN_DATA_ACK;
        IT_INV_ACK:  code = EV_IN_ACK;
        IT_READ, IT_WRITE, IT_UPG, IT_WB: begin
          if (line_hit || way_free) begin
            if (inr_type == IT_READ)    code = EV_LOAD;
            else if (inr_type == IT_WB) code = EV_WRITEBACK;
            else                        code = EV_STORE;
          end else begin
            use_victim = 1'b1;
            code = held_vic ? EV_RECALL_OWN : EV_EVICT;
          end
        end
        default: bad_type = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/coh_event_classifier.sv
module coh_event_classifier
  import cec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ACK_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rsp_valid,
  input  logic [2:0]        rsp_type,
  input  logic              rsp_from_peer,
  input  logic [ACK_W-1:0]  rsp_acks,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic              fwd_valid,
  input  logic [1:0]        fwd_type,
  input  logic [ADDR_W-1:0] fwd_addr,
  input  logic              inr_valid,
  input  logic [2:0]        inr_type,
  input  logic [ADDR_W-1:0] inr_addr,
  input  logic [4:0]        line_state,
  input  logic              line_hit,
  input  logic              way_free,
  input  logic [ADDR_W-1:0] victim_addr,
  input  logic              victim_valid,
  input  logic [4:0]        victim_state,
  input  logic [ACK_W-1:0]  pend_acks,
  input  logic              ctl_stall,
  output logic [ADDR_W-1:0] lookup_addr,
  output logic              deq_rsp,
  output logic              deq_fwd,
  output logic              deq_inr,
  output logic              ev_valid,
  output logic [4:0]        ev_code,
  output logic [ADDR_W-1:0] ev_addr,
  output logic              err_sticky
);
  logic [NUM_Q-1:0]        req;
  logic [NUM_Q-1:0]        pick;
  logic [NUM_Q*ADDR_W-1:0] addr_bus;
  ev_e                     code;
  logic                    use_victim;
  logic                    bad_type;
  logic                    go;

  assign req[Q_RSP] = rsp_valid;
  assign req[Q_FWD] = fwd_valid;
  assign req[Q_INR] = inr_valid;

  assign addr_bus[Q_RSP*ADDR_W +: ADDR_W] = rsp_addr;
  assign addr_bus[Q_FWD*ADDR_W +: ADDR_W] = fwd_addr;
  assign addr_bus[Q_INR*ADDR_W +: ADDR_W] = inr_addr;

  cec_prio_arb #(.NQ(NUM_Q)) u_arb (
    .req  (req),
    .pick (pick)
  );

  cec_onehot_mux #(.NQ(NUM_Q), .W(ADDR_W)) u_mux (
    .din  (addr_bus),
    .sel  (pick),
    .dout (lookup_addr)
  );

  cec_classify #(.ACK_W(ACK_W)) u_cls (
    .pick          (pick),
    .rsp_type      (rsp_type),
    .rsp_from_peer (rsp_from_peer),
    .rsp_acks      (rsp_acks),
    .fwd_type      (fwd_type),
    .inr_type      (inr_type),
    .line_state    (line_state),
    .line_hit      (line_hit),
    .way_free      (way_free),
    .victim_valid  (victim_valid),
    .victim_state  (victim_state),
    .pend_acks     (pend_acks),
    .code          (code),
    .use_victim    (use_victim),
    .bad_type      (bad_type)
  );

  assign go      = (|pick) & ~ctl_stall;
  assign deq_rsp = go & pick[Q_RSP];
  assign deq_fwd = go & pick[Q_FWD];
  assign deq_inr = go & pick[Q_INR] & ~use_victim;

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_valid   <= 1'b0;
      err_sticky <= 1'b0;
    end else begin
      ev_valid   <= go & ~bad_type;
      err_sticky <= err_sticky | (go & bad_type);
    end
    ev_code <= code;
    ev_addr <= use_victim ? victim_addr : lookup_addr;
  end
endmodule

// File: rtl/coh_event_classifier_chk.sv
module coh_event_classifier_chk
  import cec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ACK_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rsp_valid,
  input logic              fwd_valid,
  input logic              inr_valid,
  input logic [2:0]        inr_type,
  input logic              line_hit,
  input logic              way_free,
  input logic              ctl_stall,
  input logic              deq_rsp,
  input logic              deq_fwd,
  input logic              deq_inr,
  input logic              ev_valid,
  input logic              err_sticky
);
  p_one_pop_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({deq_rsp, deq_fwd, deq_inr}));

  p_rsp_first_r1: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !ctl_stall) |-> (deq_rsp && !deq_fwd && !deq_inr));

  p_ev_source_r2: assert property (@(posedge clk) disable iff (rst)
    ev_valid |-> $past((rsp_valid || fwd_valid || inr_valid) && !ctl_stall));

  p_victim_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (inr_valid && !rsp_valid && !fwd_valid && !ctl_stall &&
     inr_type <= IT_WB && !line_hit && !way_free) |-> !deq_inr);

  p_stall_pop_r10: assert property (@(posedge clk) disable iff (rst)
    ctl_stall |-> !(deq_rsp || deq_fwd || deq_inr));

  p_stall_ev_r10: assert property (@(posedge clk) disable iff (rst)
    ctl_stall |=> !ev_valid);

  p_err_keep_r11: assert property (@(posedge clk) disable iff (rst)
    err_sticky |=> err_sticky);
endmodule

bind coh_event_classifier coh_event_classifier_chk #(
  .ADDR_W(ADDR_W), .ACK_W(ACK_W)
) u_chk (
  .clk(clk), .rst(rst), .rsp_valid(rsp_valid), .fwd_valid(fwd_valid),
  .inr_valid(inr_valid), .inr_type(inr_type), .line_hit(line_hit),
  .way_free(way_free), .ctl_stall(ctl_stall), .deq_rsp(deq_rsp),
  .deq_fwd(deq_fwd), .deq_inr(deq_inr), .ev_valid(ev_valid),
  .err_sticky(err_sticky)
);

// File: tb/sim_coh_event_classifier.sv
module sim_coh_event_classifier;
  localparam int AW = 32;
  localparam int KW = 4;
  localparam logic [AW-1:0] A_RSP = 32'h100;
  localparam logic [AW-1:0] A_FWD = 32'h200;
  localparam logic [AW-1:0] A_INR = 32'h300;
  localparam logic [AW-1:0] A_VIC = 32'h400;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic rsp_valid, rsp_from_peer, fwd_valid, inr_valid;
  logic [2:0] rsp_type, inr_type;
  logic [1:0] fwd_type;
  logic [KW-1:0] rsp_acks, pend_acks;
  logic [4:0] line_state, victim_state;
  logic line_hit, way_free, victim_valid, ctl_stall;
  logic [AW-1:0] lookup_addr, ev_addr;
  logic deq_rsp, deq_fwd, deq_inr, ev_valid, err_sticky;
  logic [4:0] ev_code;

  coh_event_classifier #(.ADDR_W(AW), .ACK_W(KW)) u0 (
    .clk(clk), .rst(rst),
    .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_from_peer(rsp_from_peer),
    .rsp_acks(rsp_acks), .rsp_addr(A_RSP),
    .fwd_valid(fwd_valid), .fwd_type(fwd_type), .fwd_addr(A_FWD),
    .inr_valid(inr_valid), .inr_type(inr_type), .inr_addr(A_INR),
    .line_state(line_state), .line_hit(line_hit), .way_free(way_free),
    .victim_addr(A_VIC), .victim_valid(victim_valid), .victim_state(victim_state),
    .pend_acks(pend_acks), .ctl_stall(ctl_stall),
    .lookup_addr(lookup_addr), .deq_rsp(deq_rsp), .deq_fwd(deq_fwd),
    .deq_inr(deq_inr), .ev_valid(ev_valid), .ev_code(ev_code),
    .ev_addr(ev_addr), .err_sticky(err_sticky)
  );

  typedef struct packed {
    logic [3:0] rq;
    logic [2:0] qv;      // {inr,fwd,rsp}
    logic [2:0] rt;
    logic       peer;
    logic [3:0] racks;
    logic [1:0] ft;
    logic [2:0] it;
    logic [4:0] ls;
    logic       hit;
    logic       free;
    logic       vv;
    logic [4:0] vs;
    logic [3:0] pend;
    logic       stall;
    logic [2:0] edeq;    // {inr,fwd,rsp}
    logic       eval;
    logic [4:0] ecode;
    logic [1:0] easel;   // 0 rsp,1 fwd,2 inr,3 victim
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{4'd1, 3'b111, 3'd1, 1'b0, 4'd0, 2'd0, 3'd0, 5'd8,  1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b001, 1'b1, 5'd12, 2'd0}, // R1
    '{4'd1, 3'b110, 3'd0, 1'b0, 4'd0, 2'd1, 3'd0, 5'd2,  1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b010, 1'b1, 5'd6,  2'd1}, // R1
    '{4'd3, 3'b001, 3'd3, 1'b0, 4'd0, 2'd0, 3'd0, 5'd10, 1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b001, 1'b1, 5'd17, 2'd0}, // R3
    '{4'd4, 3'b001, 3'd0, 1'b1, 4'd0, 2'd0, 3'd0, 5'd7,  1'b1, 1'b1, 1'b0, 5'd0,  4'd2, 1'b0, 3'b001, 1'b1, 5'd13, 2'd0}, // R4
    '{4'd4, 3'b001, 3'd0, 1'b1, 4'd3, 2'd0, 3'd0, 5'd8,  1'b1, 1'b1, 1'b0, 5'd0,  4'd3, 1'b0, 3'b001, 1'b1, 5'd14, 2'd0}, // R4
    '{4'd4, 3'b001, 3'd0, 1'b0, 4'd1, 2'd0, 3'd0, 5'd7,  1'b1, 1'b1, 1'b0, 5'd0,  4'd2, 1'b0, 3'b001, 1'b1, 5'd11, 2'd0}, // R4
    '{4'd5, 3'b001, 3'd2, 1'b0, 4'd1, 2'd0, 3'd0, 5'd9,  1'b1, 1'b1, 1'b0, 5'd0,  4'd1, 1'b0, 3'b001, 1'b1, 5'd16, 2'd0}, // R5
    '{4'd5, 3'b001, 3'd2, 1'b0, 4'd1, 2'd0, 3'd0, 5'd9,  1'b1, 1'b1, 1'b0, 5'd0,  4'd3, 1'b0, 3'b001, 1'b1, 5'd15, 2'd0}, // R5
    '{4'd6, 3'b010, 3'd0, 1'b0, 4'd0, 2'd0, 3'd0, 5'd5,  1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b010, 1'b1, 5'd8,  2'd1}, // R6
    '{4'd6, 3'b010, 3'd0, 1'b0, 4'd0, 2'd0, 3'd0, 5'd5,  1'b0, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b010, 1'b1, 5'd5,  2'd1}, // R6
    '{4'd6, 3'b010, 3'd0, 1'b0, 4'd0, 2'd3, 3'd0, 5'd4,  1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b010, 1'b1, 5'd7,  2'd1}, // R6
    '{4'd6, 3'b010, 3'd0, 1'b0, 4'd0, 2'd2, 3'd0, 5'd16, 1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b010, 1'b1, 5'd8,  2'd1}, // R6
    '{4'd6, 3'b010, 3'd0, 1'b0, 4'd0, 2'd1, 3'd0, 5'd11, 1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b010, 1'b1, 5'd6,  2'd1}, // R6
    '{4'd7, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd4, 5'd14, 1'b0, 1'b0, 1'b0, 5'd0,  4'd0, 1'b0, 3'b100, 1'b1, 5'd3,  2'd2}, // R7
    '{4'd7, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd5, 5'd12, 1'b0, 1'b0, 1'b1, 5'd1,  4'd0, 1'b0, 3'b100, 1'b1, 5'd4,  2'd2}, // R7
    '{4'd8, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd0, 5'd2,  1'b1, 1'b0, 1'b0, 5'd0,  4'd0, 1'b0, 3'b100, 1'b1, 5'd0,  2'd2}, // R8
    '{4'd8, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd2, 5'd0,  1'b0, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b100, 1'b1, 5'd1,  2'd2}, // R8
    '{4'd8, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd3, 5'd5,  1'b1, 1'b0, 1'b0, 5'd0,  4'd0, 1'b0, 3'b100, 1'b1, 5'd2,  2'd2}, // R8
    '{4'd9, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd1, 5'd0,  1'b0, 1'b0, 1'b1, 5'd13, 4'd0, 1'b0, 3'b000, 1'b1, 5'd9,  2'd3}, // R9
    '{4'd9, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd0, 5'd0,  1'b0, 1'b0, 1'b1, 5'd6,  4'd0, 1'b0, 3'b000, 1'b1, 5'd10, 2'd3}, // R9
    '{4'd9, 3'b100, 3'd0, 1'b0, 4'd0, 2'd0, 3'd3, 5'd0,  1'b0, 1'b0, 1'b0, 5'd1,  4'd0, 1'b0, 3'b000, 1'b1, 5'd10, 2'd3}, // R9
    '{4'd10,3'b111, 3'd1, 1'b0, 4'd0, 2'd0, 3'd0, 5'd0,  1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b1, 3'b000, 1'b0, 5'd0,  2'd0}, // R10
    '{4'd2, 3'b000, 3'd0, 1'b0, 4'd0, 2'd0, 3'd0, 5'd0,  1'b1, 1'b1, 1'b0, 5'd0,  4'd0, 1'b0, 3'b000, 1'b0, 5'd0,  2'd0}  // R2
  };

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    {inr_valid, fwd_valid, rsp_valid} = v.qv;
    rsp_type = v.rt; rsp_from_peer = v.peer; rsp_acks = v.racks;
    fwd_type = v.ft; inr_type = v.it;
    line_state = v.ls; line_hit = v.hit; way_free = v.free;
    victim_valid = v.vv; victim_state = v.vs;
    pend_acks = v.pend; ctl_stall = v.stall;
  endtask

  function automatic logic [AW-1:0] addr_of(input logic [1:0] s);
    case (s)
      2'd0: addr_of = A_RSP;
      2'd1: addr_of = A_FWD;
      2'd2: addr_of = A_INR;
      default: addr_of = A_VIC;
    endcase
  endfunction

  initial begin
    drive('0);
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(ev_valid == 1'b0 && err_sticky == 1'b0, "R12 reset", {ev_valid, err_sticky}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [AW-1:0] lk;
      string tag;
      v = TBL[i];
      tag = $sformatf("R%0d vec%0d", v.rq, i);
      drive(v);
      #1;
      chk({deq_inr, deq_fwd, deq_rsp} == v.edeq, {tag, " deq"}, {deq_inr, deq_fwd, deq_rsp}, v.edeq);
      if (v.qv != 3'b000) begin
        lk = v.qv[0] ? A_RSP : (v.qv[1] ? A_FWD : A_INR);
        chk(lookup_addr == lk, {tag, " lookup"}, lookup_addr, lk);
      end
      @(negedge clk);
      if (v.eval)
        chk(ev_valid && ev_code == v.ecode && ev_addr == addr_of(v.easel), {tag, " event"},
            {ev_valid, ev_code, ev_addr}, {1'b1, v.ecode, addr_of(v.easel)});
      else
        chk(!ev_valid, {tag, " no event"}, ev_valid, 0);
    end

    // R11: undefined inner type is popped, no event, error latched
    drive('0);
    inr_valid = 1'b1; inr_type = 3'd6;
    #1;
    chk(deq_inr == 1'b1, "R11 bad inner popped", deq_inr, 1);
    @(negedge clk);
    chk(!ev_valid && err_sticky, "R11 bad inner flagged", {ev_valid, err_sticky}, 2'b01);
    // error stays while good traffic flows; R3 still decodes
    drive('0);
    rsp_valid = 1'b1; rsp_type = 3'd1;
    @(negedge clk);
    chk(err_sticky && ev_valid && ev_code == 5'd12, "R11 sticky with R3 event",
        {err_sticky, ev_valid, ev_code}, {2'b11, 5'd12});
    // undefined response type
    rsp_type = 3'd5;
    #1;
    chk(deq_rsp == 1'b1, "R11 bad response popped", deq_rsp, 1);
    @(negedge clk);
    chk(!ev_valid && err_sticky, "R11 bad response flagged", {ev_valid, err_sticky}, 2'b01);
    drive('0);
    @(negedge clk);
    chk(err_sticky == 1'b1, "R11 still set idle", err_sticky, 1);
    // R12: reset clears the latch
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!err_sticky && !ev_valid, "R12 reset clears", {err_sticky, ev_valid}, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule